// File: doc/BRIEF.md
# Seat-Belt Reminder Alarm Controller

This block watches an ignition key level and a seat-belt level and raises an alarm when the key has been turned on and the belt is still unfastened five seconds later. The alarm stops at the ten-second mark, counted from key-on. It also stops as soon as the belt is fastened or the key is turned off, whichever of the three happens first. The alarm therefore sounds for at most five seconds.

The block has three parts. A three-state control machine (idle, armed, alerting) decides what happens. A prescaler turns the clock into one-second ticks. A seconds counter shares a single count for both the warning mark and the limit mark. The counter and the control machine update on the same clock edge. Key events are taken from edges of the registered key level, and the belt input is used as a registered level. The alarm output is a registered Moore output, and the current state is also available as a small code for debug.

Top module: `belt_reminder`

## Requirements
- R1: Synchronous reset puts the controller in the idle state (code 0) with the alarm low and the seconds count cleared.
- R2: In idle, a rising edge on the registered key level moves the controller to armed (code 1) one edge after the key is sampled high, and restarts the seconds count from zero.
- R3: In armed, a sampled key-off edge or a sampled fastened belt returns the controller to idle without raising the alarm.
- R4: In armed, reaching the warning mark (WARN_SECS seconds) moves the controller to alerting (code 2), and the alarm rises. With the key sampled high at edge E0, the alarm is first high after edge E(WARN_SECS*CLKS_PER_SEC+2).
- R5: Left undisturbed, the alarm stays high for exactly (LIMIT_SECS-WARN_SECS)*CLKS_PER_SEC cycles, ends at the limit mark and returns the controller to idle. The seconds count saturates at LIMIT_SECS.
- R6: In alerting, a sampled fastened belt or a sampled key-off edge drops the alarm and returns to idle on the edge after the sampling edge.
- R7: If key-off or a fastened belt is sampled in the same cycle that the warning mark is reached, the controller goes to idle and the alarm never rises.
- R8: The alarm output is registered and is high exactly while the state code is 2.
- R9: The state code takes only the values 0 (idle), 1 (armed) and 2 (alerting), and never 3.
- R10: While the controller is idle, the belt level has no effect. A key that stays high does not start a new cycle: only a fresh rising edge does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| key_in | input | 1 | Ignition key level |
| belt_in | input | 1 | Seat belt fastened level |
| alarm | output | 1 | Registered alarm output |
| state_code | output | 2 | Debug state code: 0 idle, 1 armed, 2 alerting |

## Verification
The bench builds the block with CLKS_PER_SEC set to 4, which keeps the default warning and limit marks of 5 and 10 seconds. A full alarm episode then takes about forty cycles, so a few thousand random cycles reach every transition many times. At this size the directed tests can also place a belt or key-off event exactly in the cycle where the warning mark arrives. A cycle-level model in the bench, written from the requirements, follows the state code and the alarm on every cycle.

// File: rtl/belt_alarm_pkg.sv
package belt_alarm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_ALERT = 2'd2
    } ctl_state_e;

endpackage

// File: rtl/input_sampler.sv
module input_sampler (
    input  logic clk,
    input  logic rst,
    input  logic key_in,
    input  logic belt_in,
    output logic key_rise,
    output logic key_fall,
    output logic belt_on
);
    typedef struct packed {
        logic key_s;
        logic key_p;
        logic belt_s;
    } smp_t;

    smp_t r_d, r_q;

    always_comb begin
        r_d        = r_q;
        r_d.key_s  = key_in;
        r_d.key_p  = r_q.key_s;
        r_d.belt_s = belt_in;
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '0;
        else     r_q <= r_d;
    end

    assign key_rise = r_q.key_s & ~r_q.key_p;
    assign key_fall = ~r_q.key_s & r_q.key_p;
    assign belt_on  = r_q.belt_s;

endmodule

// File: rtl/sec_prescaler.sv
module sec_prescaler #(
    parameter int CLKS_PER_SEC = 200_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    output logic tick
);
    localparam int PW = (CLKS_PER_SEC > 1) ? $clog2(CLKS_PER_SEC) : 1;
    localparam logic [PW-1:0] LAST = PW'(CLKS_PER_SEC - 1);

    typedef struct packed {
        logic [PW-1:0] cnt;
    } pre_t;

    pre_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (clear)               r_d.cnt = '0;
        else if (r_q.cnt == LAST) r_d.cnt = '0;
        else                     r_d.cnt = r_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '0;
        else     r_q <= r_d;
    end

    assign tick = (r_q.cnt == LAST);

    assert_pre_range_R5: assert property (@(posedge clk) disable iff (rst)
        r_q.cnt <= LAST);

endmodule

// File: rtl/sec_counter.sv
module sec_counter #(
    parameter int WARN_SECS  = 5,
    parameter int LIMIT_SECS = 10,
    parameter int SW         = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          restart,
    input  logic          tick,
    output logic [SW-1:0] secs,
    output logic          at_warn,
    output logic          at_limit
);
    localparam logic [SW-1:0] WARN_V  = SW'(WARN_SECS);
    localparam logic [SW-1:0] LIMIT_V = SW'(LIMIT_SECS);

    typedef struct packed {
        logic [SW-1:0] sec;
    } cnt_t;

    cnt_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (restart)                      r_d.sec = '0;
        else if (tick && r_q.sec < LIMIT_V) r_d.sec = r_q.sec + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '0;
        else     r_q <= r_d;
    end

    assign secs     = r_q.sec;
    assign at_warn  = (r_q.sec == WARN_V);
    assign at_limit = (r_q.sec == LIMIT_V);

    assert_sec_bound_R5: assert property (@(posedge clk) disable iff (rst)
        r_q.sec <= LIMIT_V);

    assert_sec_step_R5: assert property (@(posedge clk) disable iff (rst)
        (!restart && !tick) |=> $stable(r_q.sec));

endmodule

// File: rtl/belt_ctl_fsm.sv
module belt_ctl_fsm
    import belt_alarm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       key_rise,
    input  logic       key_fall,
    input  logic       belt_on,
    input  logic       at_warn,
    input  logic       at_limit,
    output logic       start,
    output logic       alarm,
    output ctl_state_e state
);
    typedef struct packed {
        ctl_state_e st;
        logic       alarm;
    } fsm_t;

    fsm_t r_d, r_q;

    always_comb begin
        r_d   = r_q;
        start = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (key_rise) begin
                    r_d.st = ST_ARMED;
                    start  = 1'b1;
                end
            end
            ST_ARMED: begin
                if (key_fall || belt_on) r_d.st = ST_IDLE;
                else if (at_warn)        r_d.st = ST_ALERT;
            end
            ST_ALERT: begin
                if (at_limit || belt_on || key_fall) r_d.st = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
        r_d.alarm = (r_d.st == ST_ALERT);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q.st    <= ST_IDLE;
            r_q.alarm <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign alarm = r_q.alarm;
    assign state = r_q.st;

    assert_alarm_match_R8: assert property (@(posedge clk) disable iff (rst)
        r_q.alarm == (r_q.st == ST_ALERT));

    assert_code_legal_R9: assert property (@(posedge clk) disable iff (rst)
        r_q.st != 2'd3);

    assert_exit_wins_R7: assert property (@(posedge clk) disable iff (rst)
        (r_q.st == ST_ARMED && at_warn && (belt_on || key_fall)) |=> (r_q.st == ST_IDLE));

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (r_q.st == ST_IDLE && !key_rise) |=> (r_q.st == ST_IDLE));

endmodule

// File: rtl/belt_reminder.sv
module belt_reminder
    import belt_alarm_pkg::*;
#(
    parameter int CLKS_PER_SEC = 200_000_000,
    parameter int WARN_SECS    = 5,
    parameter int LIMIT_SECS   = 10
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       key_in,
    input  logic       belt_in,
    output logic       alarm,
    output logic [1:0] state_code
);
    localparam int SW = $clog2(LIMIT_SECS + 1);

    logic          key_rise, key_fall, belt_on;
    logic          tick, start, at_warn, at_limit;
    logic [SW-1:0] secs;
    ctl_state_e    st;

    input_sampler u_smp (
        .clk      (clk),
        .rst      (rst),
        .key_in   (key_in),
        .belt_in  (belt_in),
        .key_rise (key_rise),
        .key_fall (key_fall),
        .belt_on  (belt_on)
    );

    sec_prescaler #(.CLKS_PER_SEC(CLKS_PER_SEC)) u_pre (
        .clk   (clk),
        .rst   (rst),
        .clear (start),
        .tick  (tick)
    );

    sec_counter #(.WARN_SECS(WARN_SECS), .LIMIT_SECS(LIMIT_SECS), .SW(SW)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .restart  (start),
        .tick     (tick),
        .secs     (secs),
        .at_warn  (at_warn),
        .at_limit (at_limit)
    );

    belt_ctl_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .key_rise (key_rise),
        .key_fall (key_fall),
        .belt_on  (belt_on),
        .at_warn  (at_warn),
        .at_limit (at_limit),
        .start    (start),
        .alarm    (alarm),
        .state    (st)
    );

    assign state_code = st;

    assert_arm_restart_R2: assert property (@(posedge clk) disable iff (rst)
        (st == ST_ARMED && $past(st) == ST_IDLE) |-> (secs == '0));

    assert_alert_entry_R4: assert property (@(posedge clk) disable iff (rst)
        (st == ST_ALERT && $past(st) == ST_ARMED) |-> $past(at_warn));

    assert_alert_exit_R6: assert property (@(posedge clk) disable iff (rst)
        (st == ST_ALERT && (belt_on || key_fall)) |=> (st == ST_IDLE && !alarm));

endmodule

// File: tb/belt_reminder_tb_top.sv
`timescale 1ns/1ps
module belt_reminder_tb_top;
    localparam int C     = 4;
    localparam int WARN  = 5;
    localparam int LIMIT = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       key_in = 1'b0;
    logic       belt_in = 1'b0;
    logic       alarm;
    logic [1:0] state_code;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    belt_reminder #(.CLKS_PER_SEC(C), .WARN_SECS(WARN), .LIMIT_SECS(LIMIT)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .key_in     (key_in),
        .belt_in    (belt_in),
        .alarm      (alarm),
        .state_code (state_code)
    );

    // Reference model built from the requirements
    int m_st = 0, m_pre = 0, m_sec = 0;
    bit m_ks = 0, m_kp = 0, m_bs = 0;

    function automatic int next_state(int s, bit rise, bit fall, bit belt, int sec);
        case (s)
            0: return rise ? 1 : 0;
            1: if (fall || belt) return 0; else if (sec == WARN) return 2; else return 1;
            2: return (sec == LIMIT || belt || fall) ? 0 : 2;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_st = 0; m_pre = 0; m_sec = 0; m_ks = 0; m_kp = 0; m_bs = 0;
        end else begin
            bit rise, fall, strt;
            rise = m_ks & !m_kp;
            fall = !m_ks & m_kp;
            strt = (m_st == 0) && rise;
            m_st = next_state(m_st, rise, fall, m_bs, m_sec);
            if (strt) begin
                m_pre = 0; m_sec = 0;
            end else if (m_pre == C - 1) begin
                m_pre = 0;
                if (m_sec < LIMIT) m_sec++;
            end else begin
                m_pre++;
            end
            m_kp = m_ks; m_ks = key_in; m_bs = belt_in;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp_v);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp_v, $time);
        end
    endtask

    // Cycle compare against the model (R8 alarm, R9 state code)
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk(state_code == 2'(m_st), "R9 state code vs model", state_code, m_st);
            chk(alarm == (m_st == 2), "R8 alarm vs model", alarm, m_st == 2);
        end
    end

    task automatic settle();
        key_in = 0; belt_in = 0;
        repeat (4) @(negedge clk);
    endtask

    int n, d;
    bit seen;

    initial begin
        repeat (3) @(negedge clk);
        chk(state_code == 0, "R1 reset state", state_code, 0);
        chk(alarm == 0, "R1 reset alarm", alarm, 0);
        rst = 0;
        @(negedge clk);

        // R2, R4, R5: undisturbed episode
        key_in = 1;
        n = 0;
        repeat (2) begin @(negedge clk); n++; end
        chk(state_code == 1, "R2 armed after key rise", state_code, 1);
        while (!alarm && n < 300) begin @(negedge clk); n++; end
        chk(n == WARN*C + 3, "R4 alarm rise cycle", n, WARN*C + 3);
        d = 0;
        while (alarm && d < 300) begin @(negedge clk); d++; end
        chk(d == (LIMIT-WARN)*C, "R5 alarm duration", d, (LIMIT-WARN)*C);
        chk(state_code == 0, "R5 idle after limit", state_code, 0);

        // R10: key held high does not retrigger
        seen = 0;
        repeat (100) begin @(negedge clk); if (state_code != 0) seen = 1; end
        chk(!seen, "R10 held key no retrigger", seen, 0);
        settle();

        // R10: belt toggling while idle
        seen = 0;
        for (int i = 0; i < 60; i++) begin
            belt_in = i[2];
            @(negedge clk);
            if (state_code != 0 || alarm) seen = 1;
        end
        chk(!seen, "R10 belt ignored in idle", seen, 0);
        settle();

        // R3: key off while armed
        key_in = 1;
        repeat (3) @(negedge clk);
        key_in = 0;
        repeat (2) @(negedge clk);
        chk(state_code == 0, "R3 key off in armed", state_code, 0);
        seen = 0;
        repeat (60) begin @(negedge clk); if (alarm) seen = 1; end
        chk(!seen, "R3 no alarm after key off", seen, 0);
        settle();

        // R3: belt fastened while armed
        key_in = 1;
        repeat (6) @(negedge clk);
        belt_in = 1;
        repeat (2) @(negedge clk);
        chk(state_code == 0, "R3 belt in armed", state_code, 0);
        settle();

        // R6: belt during alert
        key_in = 1;
        n = 0;
        while (!alarm && n < 300) begin @(negedge clk); n++; end
        repeat (3) @(negedge clk);
        belt_in = 1;
        @(negedge clk);
        chk(alarm == 1, "R6 alarm one cycle after belt", alarm, 1);
        @(negedge clk);
        chk(alarm == 0, "R6 alarm drops on belt", alarm, 0);
        settle();

        // R6: key off during alert
        key_in = 1;
        n = 0;
        while (!alarm && n < 300) begin @(negedge clk); n++; end
        repeat (5) @(negedge clk);
        key_in = 0;
        repeat (2) @(negedge clk);
        chk(alarm == 0, "R6 alarm drops on key off", alarm, 0);
        chk(state_code == 0, "R6 idle after key off", state_code, 0);
        settle();

        // R7: belt sampled together with warning mark
        key_in = 1;
        repeat (WARN*C + 1) @(negedge clk);
        belt_in = 1;
        seen = 0;
        repeat (2) begin @(negedge clk); if (alarm) seen = 1; end
        chk(state_code == 0, "R7 belt beats warning", state_code, 0);
        repeat (40) begin @(negedge clk); if (alarm) seen = 1; end
        chk(!seen, "R7 no alarm with belt at mark", seen, 0);
        settle();

        // R7: key off sampled together with warning mark
        key_in = 1;
        repeat (WARN*C + 1) @(negedge clk);
        key_in = 0;
        seen = 0;
        repeat (40) begin @(negedge clk); if (alarm) seen = 1; end
        chk(!seen, "R7 no alarm with key off at mark", seen, 0);
        settle();

        // Random phase, compared cycle by cycle against the model
        void'($urandom(32'd1234));
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 59) == 0) key_in = ~key_in;
            if ($urandom_range(0, 79) == 0) belt_in = ~belt_in;
            if (i % 997 == 996) begin rst = 1; @(negedge clk); rst = 0; end
            @(negedge clk);
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(150000 * 5);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule